// File: doc/BRIEF.md
# Vectored Dual-Path Interrupt Controller

This block collects up to 64 interrupt lines and presents them to a processor on two outputs: a normal interrupt and a fast interrupt. Each line passes through a two-stage synchronizer. Configuration then decides, line by line, whether it counts when it is active or when it changes, which level or edge is active, whether it is enabled, and which of the two outputs it goes to. Software can also force a line pending through a soft-force register.

Software sees the block through a simple synchronous bus that reads and writes 32-bit words. Per-line state is held in two 32-bit banks. Line n sits in bank n/32 at bit n mod 32, and the bank-1 word of every per-line register is 4 bytes above the bank-0 word. A read of a path's vector word returns the lowest-numbered eligible pending line and marks it in service. While a line is in service, that path only fires again for a lower-numbered line. A write of any value to the path's end-of-service word releases it.

Register word offsets, in bytes, are as follows. The bank-0 / bank-1 pairs are: route 0x00/0x04, type 0x08/0x0C, polarity 0x10/0x14, enable 0x18/0x1C, enable-set 0x20/0x24, enable-clear 0x28/0x2C, pending-clear 0x30/0x34, soft-force 0x38/0x3C, raw 0x40/0x44, normal-path status 0x48/0x4C, fast-path status 0x50/0x54. The single words are: master 0x58, empty-code 0x5C, normal vector 0x60, normal end-of-service 0x64, fast vector 0x68, fast end-of-service 0x6C, normal in-service 0x70, fast in-service 0x74. Read data appears on the bus output one clock after the read request.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, the configuration, enable, soft-force and master registers read 0, both outputs are low, and the vector, in-service and empty-code words (0x60, 0x68, 0x70, 0x74, 0x5C) read the empty code 0x80.
- R2: Line n maps to bank n/32, bit n mod 32. For example, line 63 shows as bit 31 of the bank-1 words, and its vector reads 63.
- R3: In level mode (type bit 0), a polarity bit of 0 makes a high input pending and a polarity bit of 1 makes a low input pending. The raw word follows the input two clocks after a change.
- R4: In edge mode (type bit 1), a rising edge (polarity 0) or a falling edge (polarity 1) latches the line pending. The pending state stays after the input returns, and an edge of the other direction latches nothing. A 1 written to pending-clear (0x30/0x34) removes the pending state, but an edge detected in the same cycle as that clear keeps the line pending.
- R5: Writing enable-set (0x20/0x24) sets the enable bits where the data is 1. Writing enable-clear (0x28/0x2C) clears them where the data is 1. Zero bits leave the enables unchanged, and the result reads back at 0x18/0x1C.
- R6: A route bit of 1 places a pending, enabled line in the fast-path status and on fiq_o. A route bit of 0 places it in the normal-path status and on irq_o.
- R7: Master bit 0 gates irq_o and master bit 1 gates fiq_o. The status words and vector reads are not gated by the master bits.
- R8: A vector read returns the lowest-numbered eligible pending line of that path, or 0x80 when there is none.
- R9: A vector read that returns a line records that line as in service, readable at 0x70/0x74. Until a write to the path's end-of-service word, the path asserts its output and returns a line only for a strictly lower line number.
- R10: Writing soft-force (0x38/0x3C) makes the lines with 1 bits pending and reads back at the same offsets. A pending-clear write removes the forced state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Interrupt lines, asynchronous |
| bus_req_i | input | 1 | Bus access request for this cycle |
| bus_we_i | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr_i | input | 8 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one clock after the read request |
| irq_o | output | 1 | Normal-path interrupt request |
| fiq_o | output | 1 | Fast-path interrupt request |

## Verification
A pending-clear write and an edge capture can land in the same clock on the same line. The bench leaves a line latched in edge mode and raises its input. It then times the clear write to hit the exact edge where the synchronized edge is recognised, two clocks after the input change, and expects the raw word to still show the line. A separate clear with no edge must empty the line, so the check only passes when the new edge takes precedence.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned ADDR_W = 8;

  // word indices (byte address >> 2); bank-1 copy sits at index + 1
  localparam logic [5:0] W_ROUTE  = 6'd0;
  localparam logic [5:0] W_TYPE   = 6'd2;
  localparam logic [5:0] W_POL    = 6'd4;
  localparam logic [5:0] W_EN     = 6'd6;
  localparam logic [5:0] W_ENSET  = 6'd8;
  localparam logic [5:0] W_ENCLR  = 6'd10;
  localparam logic [5:0] W_CLR    = 6'd12;
  localparam logic [5:0] W_SOFT   = 6'd14;
  localparam logic [5:0] W_RAW    = 6'd16;
  localparam logic [5:0] W_IRQST  = 6'd18;
  localparam logic [5:0] W_FIQST  = 6'd20;
  localparam logic [5:0] W_MASTER = 6'd22;
  localparam logic [5:0] W_EMPTY  = 6'd23;
  localparam logic [5:0] W_IRQVEC = 6'd24;
  localparam logic [5:0] W_IRQEOS = 6'd25;
  localparam logic [5:0] W_FIQVEC = 6'd26;
  localparam logic [5:0] W_FIQEOS = 6'd27;
  localparam logic [5:0] W_IRQSVC = 6'd28;
  localparam logic [5:0] W_FIQSVC = 6'd29;

  localparam int unsigned N_PATH = 2;
  localparam int unsigned P_IRQ  = 0;
  localparam int unsigned P_FIQ  = 1;
endpackage

// File: rtl/vint_detect.sv
module vint_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] soft_set_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] soft_o
);
  logic [N-1:0] meta_q, sync_q, prev_q, latch_q, soft_q;
  logic [N-1:0] act, rise;

  // polarity folded in before edge detection
  assign act  = sync_q ^ pol_i;
  assign rise = act & ~(prev_q ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= '0;
      sync_q  <= '0;
      prev_q  <= '0;
      latch_q <= '0;
      soft_q  <= '0;
    end else begin
      meta_q  <= src_i;
      sync_q  <= meta_q;
      prev_q  <= sync_q;
      // a fresh edge wins over a same-cycle clear
      latch_q <= ((latch_q & ~clr_i) | rise) & edge_i;
      soft_q  <= (soft_q & ~clr_i) | soft_set_i;
    end
  end

  assign raw_o  = (edge_i & latch_q) | (~edge_i & act) | soft_q;
  assign soft_o = soft_q;
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int unsigned N   = 64,
  parameter int unsigned IDW = 6
) (
  input  logic [N-1:0]   req_i,
  output logic           valid_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDW'(i);
    end
  end
endmodule

// File: rtl/vint_path.sv
module vint_path #(
  parameter int unsigned N   = 64,
  parameter int unsigned IDW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   pend_i,
  input  logic           gate_i,
  input  logic           ack_i,
  input  logic           eos_i,
  output logic           vec_valid_o,
  output logic [IDW-1:0] vec_o,
  output logic           out_o,
  output logic           svc_valid_o,
  output logic [IDW-1:0] svc_id_o
);
  logic           top_v;
  logic [IDW-1:0] top_idx;
  logic           eligible;
  logic           svc_v_q, out_q;
  logic [IDW-1:0] svc_id_q;

  vint_prio #(.N(N), .IDW(IDW)) u_prio (
    .req_i  (pend_i),
    .valid_o(top_v),
    .idx_o  (top_idx)
  );

  // only a strictly lower number pre-empts the line in service
  assign eligible = top_v && (!svc_v_q || (top_idx < svc_id_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_v_q  <= 1'b0;
      svc_id_q <= '0;
      out_q    <= 1'b0;
    end else begin
      if (ack_i && eligible) begin
        svc_v_q  <= 1'b1;
        svc_id_q <= top_idx;
      end else if (eos_i) begin
        svc_v_q  <= 1'b0;
      end
      out_q <= gate_i && eligible;
    end
  end

  assign vec_valid_o = eligible;
  assign vec_o       = top_idx;
  assign out_o       = out_q;
  assign svc_valid_o = svc_v_q;
  assign svc_id_o    = svc_id_q;
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
#(
  parameter int unsigned NSRC    = 64,
  parameter logic [31:0] EMPTY_V = 32'h0000_0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned NBANK = NSRC / BANK_W;
  localparam int unsigned IDW   = $clog2(NSRC);

  logic [NSRC-1:0] route_q, type_q, pol_q, en_q;
  logic [1:0]      master_q;
  logic [NSRC-1:0] raw_all, soft_all, irq_stat, fiq_stat, clr_mask, soft_set;
  logic [NBANK-1:0] wr_route, wr_type, wr_pol, wr_en, wr_enset, wr_enclr;
  logic            wr, rd;
  logic [5:0]      widx;
  logic [31:0]     rd_val, rdata_q;

  logic [N_PATH-1:0]          ack, eos, path_vld, path_out, svc_v;
  logic [N_PATH-1:0][IDW-1:0] path_idx, svc_id;
  logic [N_PATH-1:0][NSRC-1:0] path_pend;

  assign wr   = bus_req_i && bus_we_i;
  assign rd   = bus_req_i && !bus_we_i;
  assign widx = bus_addr_i[ADDR_W-1:2];

  always_comb begin
    clr_mask = '0;
    soft_set = '0;
    for (int b = 0; b < NBANK; b++) begin
      wr_route[b] = wr && (widx == W_ROUTE + 6'(b));
      wr_type[b]  = wr && (widx == W_TYPE  + 6'(b));
      wr_pol[b]   = wr && (widx == W_POL   + 6'(b));
      wr_en[b]    = wr && (widx == W_EN    + 6'(b));
      wr_enset[b] = wr && (widx == W_ENSET + 6'(b));
      wr_enclr[b] = wr && (widx == W_ENCLR + 6'(b));
      if (wr && (widx == W_CLR + 6'(b)))  clr_mask[b*BANK_W +: BANK_W] = bus_wdata_i;
      if (wr && (widx == W_SOFT + 6'(b))) soft_set[b*BANK_W +: BANK_W] = bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q  <= '0;
      type_q   <= '0;
      pol_q    <= '0;
      en_q     <= '0;
      master_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (wr_route[b]) route_q[b*BANK_W +: BANK_W] <= bus_wdata_i;
        if (wr_type[b])  type_q[b*BANK_W +: BANK_W]  <= bus_wdata_i;
        if (wr_pol[b])   pol_q[b*BANK_W +: BANK_W]   <= bus_wdata_i;
        if (wr_en[b])
          en_q[b*BANK_W +: BANK_W] <= bus_wdata_i;
        else if (wr_enset[b])
          en_q[b*BANK_W +: BANK_W] <= en_q[b*BANK_W +: BANK_W] | bus_wdata_i;
        else if (wr_enclr[b])
          en_q[b*BANK_W +: BANK_W] <= en_q[b*BANK_W +: BANK_W] & ~bus_wdata_i;
      end
      if (wr && widx == W_MASTER) master_q <= bus_wdata_i[1:0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vint_detect #(.N(BANK_W)) u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .pol_i     (pol_q[b*BANK_W +: BANK_W]),
      .edge_i    (type_q[b*BANK_W +: BANK_W]),
      .clr_i     (clr_mask[b*BANK_W +: BANK_W]),
      .soft_set_i(soft_set[b*BANK_W +: BANK_W]),
      .raw_o     (raw_all[b*BANK_W +: BANK_W]),
      .soft_o    (soft_all[b*BANK_W +: BANK_W])
    );
  end

  assign irq_stat = raw_all & en_q & ~route_q;
  assign fiq_stat = raw_all & en_q & route_q;
  assign path_pend[P_IRQ] = irq_stat;
  assign path_pend[P_FIQ] = fiq_stat;

  assign ack[P_IRQ] = rd && (widx == W_IRQVEC);
  assign ack[P_FIQ] = rd && (widx == W_FIQVEC);
  assign eos[P_IRQ] = wr && (widx == W_IRQEOS);
  assign eos[P_FIQ] = wr && (widx == W_FIQEOS);

  for (genvar p = 0; p < N_PATH; p++) begin : g_path
    vint_path #(.N(NSRC), .IDW(IDW)) u_path (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pend_i     (path_pend[p]),
      .gate_i     (master_q[p]),
      .ack_i      (ack[p]),
      .eos_i      (eos[p]),
      .vec_valid_o(path_vld[p]),
      .vec_o      (path_idx[p]),
      .out_o      (path_out[p]),
      .svc_valid_o(svc_v[p]),
      .svc_id_o   (svc_id[p])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (widx == W_ROUTE + 6'(b)) rd_val = route_q[b*BANK_W +: BANK_W];
      if (widx == W_TYPE  + 6'(b)) rd_val = type_q[b*BANK_W +: BANK_W];
      if (widx == W_POL   + 6'(b)) rd_val = pol_q[b*BANK_W +: BANK_W];
      if (widx == W_EN    + 6'(b)) rd_val = en_q[b*BANK_W +: BANK_W];
      if (widx == W_SOFT  + 6'(b)) rd_val = soft_all[b*BANK_W +: BANK_W];
      if (widx == W_RAW   + 6'(b)) rd_val = raw_all[b*BANK_W +: BANK_W];
      if (widx == W_IRQST + 6'(b)) rd_val = irq_stat[b*BANK_W +: BANK_W];
      if (widx == W_FIQST + 6'(b)) rd_val = fiq_stat[b*BANK_W +: BANK_W];
    end
    case (widx)
      W_MASTER: rd_val = {30'b0, master_q};
      W_EMPTY:  rd_val = EMPTY_V;
      W_IRQVEC: rd_val = path_vld[P_IRQ] ? 32'(path_idx[P_IRQ]) : EMPTY_V;
      W_FIQVEC: rd_val = path_vld[P_FIQ] ? 32'(path_idx[P_FIQ]) : EMPTY_V;
      W_IRQSVC: rd_val = svc_v[P_IRQ] ? 32'(svc_id[P_IRQ]) : EMPTY_V;
      W_FIQSVC: rd_val = svc_v[P_FIQ] ? 32'(svc_id[P_FIQ]) : EMPTY_V;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = path_out[P_IRQ];
  assign fiq_o       = path_out[P_FIQ];
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk
  import vint_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [1:0]        master_i,
  input logic [NSRC-1:0]   en_i,
  input logic [NSRC-1:0]   raw_i,
  input logic              irq_svc_i,
  input logic              irq_o,
  input logic              fiq_o
);
  logic wr;
  logic [5:0] widx;
  assign wr   = bus_req_i && bus_we_i;
  assign widx = bus_addr_i[ADDR_W-1:2];

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i[0] |=> !irq_o);

  assert_fiq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i[1] |=> !fiq_o);

  assert_enset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == W_ENSET) |=> ((en_i[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_enclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == W_ENCLR) |=> ((en_i[31:0] & $past(bus_wdata_i)) == 32'b0));

  assert_soft_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == W_SOFT) |=> ((raw_i[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_eos_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == W_IRQEOS) |=> !irq_svc_i);
endmodule

bind vint_ctrl vint_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .master_i   (master_q),
  .en_i       (en_q),
  .raw_i      (raw_all),
  .irq_svc_i  (svc_v[0]),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/vint_ctrl_test.sv
`timescale 1ns/1ps
module vint_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vint_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  rq;
  } op_t;

  localparam int NOPS = 24;
  localparam op_t OPS [NOPS] = '{
    '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 4'd1},   // R1 route
    '{1'b0, 8'h18, 32'h0, 32'h0000_0000, 4'd1},   // R1 enable
    '{1'b0, 8'h60, 32'h0, 32'h0000_0080, 4'd1},   // R1 normal vector empty
    '{1'b0, 8'h68, 32'h0, 32'h0000_0080, 4'd8},   // R8 fast vector empty
    '{1'b0, 8'h5C, 32'h0, 32'h0000_0080, 4'd1},   // R1 empty code
    '{1'b1, 8'h20, 32'h0000_00F0, 32'h0, 4'd5},
    '{1'b1, 8'h24, 32'h8000_0001, 32'h0, 4'd2},
    '{1'b0, 8'h18, 32'h0, 32'h0000_00F0, 4'd5},   // R5
    '{1'b0, 8'h1C, 32'h0, 32'h8000_0001, 4'd2},   // R2 bank-1 copy
    '{1'b1, 8'h28, 32'h0000_0030, 32'h0, 4'd5},
    '{1'b0, 8'h18, 32'h0, 32'h0000_00C0, 4'd5},   // R5 zeros untouched
    '{1'b1, 8'h3C, 32'h0000_0001, 32'h0, 4'd10},
    '{1'b0, 8'h44, 32'h0, 32'h0000_0001, 4'd10},  // R10 forced pending
    '{1'b0, 8'h4C, 32'h0, 32'h0000_0001, 4'd2},   // R2 line 32
    '{1'b1, 8'h04, 32'h0000_0001, 32'h0, 4'd6},
    '{1'b0, 8'h4C, 32'h0, 32'h0000_0000, 4'd6},   // R6
    '{1'b0, 8'h54, 32'h0, 32'h0000_0001, 4'd6},   // R6
    '{1'b0, 8'h68, 32'h0, 32'h0000_0020, 4'd8},   // R8 line 32
    '{1'b0, 8'h74, 32'h0, 32'h0000_0020, 4'd9},   // R9
    '{1'b1, 8'h6C, 32'h0000_0000, 32'h0, 4'd9},
    '{1'b0, 8'h74, 32'h0, 32'h0000_0080, 4'd9},   // R9 released
    '{1'b1, 8'h34, 32'h0000_0001, 32'h0, 4'd10},
    '{1'b0, 8'h44, 32'h0, 32'h0000_0000, 4'd10},  // R10 cleared
    '{1'b0, 8'h3C, 32'h0, 32'h0000_0000, 4'd10}   // R10 readback
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 irq_o", {31'b0, irq}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq}, 32'h0);

    for (int i = 0; i < NOPS; i++) begin
      if (OPS[i].wr) bus_wr(OPS[i].a, OPS[i].d);
      else rd_chk($sformatf("R%0d table %0d", OPS[i].rq, i), OPS[i].a, OPS[i].exp);
    end

    // R3 level, active high
    src[6] = 1'b1;
    wait_cyc(4);
    rd_chk("R3 level high", 8'h40, 32'h0000_0040);
    rd_chk("R7 status ungated", 8'h48, 32'h0000_0040);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    bus_wr(8'h58, 32'h1);
    wait_cyc(2);
    check("R7 irq enabled", {31'b0, irq}, 32'h1);
    src[6] = 1'b0;
    wait_cyc(4);
    check("R3 level drop", {31'b0, irq}, 32'h0);
    bus_wr(8'h10, 32'h0000_0080);
    wait_cyc(1);
    rd_chk("R3 active low", 8'h40, 32'h0000_0080);
    bus_wr(8'h10, 32'h0);
    rd_chk("R3 polarity back", 8'h40, 32'h0);

    // R4 edge mode
    bus_wr(8'h08, 32'h0000_0040);
    src[6] = 1'b1;
    wait_cyc(3);
    src[6] = 1'b0;
    wait_cyc(4);
    rd_chk("R4 rise latched", 8'h40, 32'h0000_0040);
    bus_wr(8'h30, 32'h0000_0040);
    rd_chk("R4 cleared", 8'h40, 32'h0);
    bus_wr(8'h10, 32'h0000_0040);
    rd_chk("R4 no spurious", 8'h40, 32'h0);
    src[6] = 1'b1;
    wait_cyc(4);
    rd_chk("R4 rise ignored neg", 8'h40, 32'h0);
    src[6] = 1'b0;
    wait_cyc(4);
    rd_chk("R4 fall latched", 8'h40, 32'h0000_0040);
    bus_wr(8'h30, 32'h0000_0040);
    bus_wr(8'h10, 32'h0);

    // R4 clear in the cycle a new edge is seen
    src[6] = 1'b1;
    wait_cyc(4);
    src[6] = 1'b0;
    wait_cyc(4);
    @(negedge clk);
    src[6] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h30; wdata = 32'h0000_0040;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd_chk("R4 edge beats clear", 8'h40, 32'h0000_0040);
    src[6] = 1'b0;
    wait_cyc(4);
    bus_wr(8'h30, 32'h0000_0040);
    bus_wr(8'h08, 32'h0);
    rd_chk("R4 idle", 8'h40, 32'h0);

    // R8 / R9 priority and in-service
    bus_wr(8'h20, 32'h0000_0228);
    bus_wr(8'h38, 32'h0000_0220);
    wait_cyc(2);
    check("R9 irq before ack", {31'b0, irq}, 32'h1);
    rd_chk("R8 lowest of 5,9", 8'h60, 32'd5);
    wait_cyc(2);
    check("R9 blocked lower prio", {31'b0, irq}, 32'h0);
    rd_chk("R9 in service", 8'h70, 32'd5);
    rd_chk("R9 vector blocked", 8'h60, 32'h0000_0080);
    bus_wr(8'h38, 32'h0000_0008);
    wait_cyc(2);
    check("R9 pre-empt", {31'b0, irq}, 32'h1);
    rd_chk("R8 line 3", 8'h60, 32'd3);
    bus_wr(8'h64, 32'h0);
    wait_cyc(2);
    check("R9 after release", {31'b0, irq}, 32'h1);
    rd_chk("R8 next lowest", 8'h60, 32'd3);
    bus_wr(8'h64, 32'h0);
    bus_wr(8'h30, 32'h0000_0228);
    rd_chk("R8 none left", 8'h60, 32'h0000_0080);
    bus_wr(8'h64, 32'h0);

    // R6 / R7 fast path
    bus_wr(8'h3C, 32'h0000_0001);
    wait_cyc(2);
    check("R7 fiq masked", {31'b0, fiq}, 32'h0);
    bus_wr(8'h58, 32'h3);
    wait_cyc(2);
    check("R7 fiq enabled", {31'b0, fiq}, 32'h1);
    check("R6 not on irq", {31'b0, irq}, 32'h0);
    bus_wr(8'h58, 32'h1);
    wait_cyc(2);
    check("R7 fiq gated off", {31'b0, fiq}, 32'h0);
    rd_chk("R7 fast status", 8'h54, 32'h0000_0001);
    bus_wr(8'h34, 32'h0000_0001);

    // R2 top line
    src[63] = 1'b1;
    wait_cyc(4);
    rd_chk("R2 line 63 status", 8'h4C, 32'h8000_0000);
    rd_chk("R2 line 63 vector", 8'h60, 32'd63);
    bus_wr(8'h64, 32'h0);
    src[63] = 1'b0;
    wait_cyc(4);

    done = 1;
    summary();
    $finish;
  end
endmodule